// File: doc/BRIEF.md
# Burst Address Sequencer

This block supplies the word address for a synchronous burst memory. When a burst opens, it captures an external word address. It then generates the next three addresses of the four-word group by itself. The low two address bits come from a base value and a step counter. The upper bits stay fixed as they were captured.

Two active-low strobes can open a burst. One comes from a processor and one from a cache controller. When both are asserted in the same cycle, the processor wins. An active-low advance input moves the step counter forward. A mode input selects the order:

- Low selects linear order, which adds the step count to the captured low bits.
- High selects interleaved order, which XORs the step count into the captured low bits.

All inputs are sampled on the rising clock edge, and the outputs follow from registered state. The outputs report three things: the current address, the position within the burst, and which strobe opened the burst.

Top module: `burst_addr_seq`

## Requirements
- R1: After reset is asserted (rst_n low), word_addr is 0, burst_pos is 0 and burst_src is 0 (no burst).
- R2: When cpu_strobe_n is low at a rising edge, from the next cycle word_addr equals the sampled addr_in, burst_pos is 0 and burst_src is 1 (processor).
- R3: When cache_strobe_n is low and cpu_strobe_n is high at a rising edge, from the next cycle word_addr equals the sampled addr_in, burst_pos is 0 and burst_src is 2 (cache controller).
- R4: When both strobes are low at the same edge, the processor strobe wins and burst_src becomes 1.
- R5: With order_sel sampled low, the low two bits of word_addr equal (captured low bits + burst_pos) modulo 4.
- R6: With order_sel sampled high, the low two bits of word_addr equal the captured low bits XOR burst_pos. The registered mode also applies when it changes in the middle of a burst.
- R7: At an edge with both strobes high and step_n low, burst_pos increases by 1 modulo 4. With step_n high it does not change.
- R8: The bits of word_addr above the low two never change except when a strobe loads a new address. A wrap of the counter never carries into them.
- R9: At an edge with both strobes high, step_n high and order_sel unchanged, word_addr holds its value, and a change on addr_in has no effect.
- R10: A strobe in the middle of a burst reloads the address and restarts burst_pos at 0, even if step_n is low in that cycle.
- R11: Inputs are sampled only at the rising clock edge, and the outputs change one cycle after the sampled inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_strobe_n | input | 1 | Processor burst-start strobe, active low |
| cache_strobe_n | input | 1 | Cache-controller burst-start strobe, active low |
| step_n | input | 1 | Advance request, active low |
| order_sel | input | 1 | 0 = linear order, 1 = interleaved order |
| addr_in | input | ADDR_W | External word address captured at burst start |
| word_addr | output | ADDR_W | Current word address |
| burst_pos | output | CNT_W | Step count within the burst |
| burst_src | output | 2 | Burst opener: 0 none, 1 processor, 2 cache controller |

## Verification
Several functions can fall on the same clock edge. The two strobes can collide with each other. A strobe can also arrive together with an advance request in the middle of a burst. The stimulus table drives both strobes low with step_n low in one cycle. In a later cycle it drives the cache strobe alone with step_n low, partway through an interleaved burst. A collision is judged correct when burst_src reports the processor, burst_pos reads 0 rather than an advanced count, and word_addr equals the newly sampled address.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;
    typedef enum logic [1:0] {
        SRC_NONE  = 2'd0,
        SRC_CPU   = 2'd1,
        SRC_CACHE = 2'd2
    } src_e;
endpackage

// File: rtl/bsq_start_arb.sv
module bsq_start_arb
    import burst_seq_pkg::*;
(
    input  logic cpu_strobe_n,
    input  logic cache_strobe_n,
    output logic load,
    output src_e load_src
);
    always_comb begin
        load     = 1'b0;
        load_src = SRC_NONE;
        if (!cpu_strobe_n) begin
            load     = 1'b1;
            load_src = SRC_CPU;
        end else if (!cache_strobe_n) begin
            load     = 1'b1;
            load_src = SRC_CACHE;
        end
    end

    // R4: the processor strobe always takes precedence
    always_comb begin
        if (!cpu_strobe_n) begin
            a_r4_cpu_first: assert (load_src == SRC_CPU);
        end
    end
endmodule

// File: rtl/bsq_order.sv
module bsq_order #(
    parameter int CNT_W = 2
) (
    input  logic             interleave,
    input  logic [CNT_W-1:0] base_low,
    input  logic [CNT_W-1:0] step_cnt,
    output logic [CNT_W-1:0] low_out
);
    logic [CNT_W-1:0] lin_low;
    logic [CNT_W-1:0] xor_low;

    assign lin_low = base_low + step_cnt;

    genvar g;
    generate
        for (g = 0; g < CNT_W; g++) begin : g_xor
            assign xor_low[g] = base_low[g] ^ step_cnt[g];
        end
    endgenerate

    assign low_out = interleave ? xor_low : lin_low;

    // R5: at step 0 both orders return the base
    always_comb begin
        if (step_cnt == '0) begin
            a_r5_zero_step: assert (low_out == base_low);
        end
    end
endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
    import burst_seq_pkg::*;
#(
    parameter int ADDR_W = 18,
    parameter int CNT_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_strobe_n,
    input  logic              cache_strobe_n,
    input  logic              step_n,
    input  logic              order_sel,
    input  logic [ADDR_W-1:0] addr_in,
    output logic [ADDR_W-1:0] word_addr,
    output logic [CNT_W-1:0]  burst_pos,
    output logic [1:0]        burst_src
);
    localparam int HI_W = ADDR_W - CNT_W;

    typedef struct packed {
        logic [ADDR_W-1:0] base;
        logic [CNT_W-1:0]  cnt;
        logic              ilv;
        src_e              src;
    } seq_state_t;

    seq_state_t st_d, st_q;
    logic       load;
    src_e       load_src;
    logic [CNT_W-1:0] low_bits;

    bsq_start_arb u_arb (
        .cpu_strobe_n   (cpu_strobe_n),
        .cache_strobe_n (cache_strobe_n),
        .load           (load),
        .load_src       (load_src)
    );

    bsq_order #(.CNT_W(CNT_W)) u_order (
        .interleave (st_q.ilv),
        .base_low   (st_q.base[CNT_W-1:0]),
        .step_cnt   (st_q.cnt),
        .low_out    (low_bits)
    );

    always_comb begin
        st_d     = st_q;
        st_d.ilv = order_sel;
        if (load) begin
            st_d.base = addr_in;
            st_d.cnt  = '0;
            st_d.src  = load_src;
        end else if (!step_n) begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{base: '0, cnt: '0, ilv: 1'b0, src: SRC_NONE};
        end else begin
            st_q <= st_d;
        end
    end

    assign word_addr = {st_q.base[ADDR_W-1:CNT_W], low_bits};
    assign burst_pos = st_q.cnt;
    assign burst_src = st_q.src;

    // R2/R3/R10: a load presents the sampled address at step 0
    a_r10_reload: assert property (@(posedge clk) disable iff (!rst_n)
        (!cpu_strobe_n || !cache_strobe_n) |=>
            (word_addr == $past(addr_in)) && (burst_pos == '0));

    // R4: collision reports the processor
    a_r4_src_cpu: assert property (@(posedge clk) disable iff (!rst_n)
        !cpu_strobe_n |=> burst_src == 2'(SRC_CPU));

    // R7: advance without strobe increments position
    a_r7_advance: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_strobe_n && cache_strobe_n && !step_n) |=>
            burst_pos == CNT_W'($past(burst_pos) + 1'b1));

    // R8: upper bits fixed without a strobe
    a_r8_upper_fixed: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_strobe_n && cache_strobe_n) |=>
            word_addr[ADDR_W-1:CNT_W] == $past(word_addr[ADDR_W-1:CNT_W]));

    // R9: idle cycle holds the address
    a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_strobe_n && cache_strobe_n && step_n && (order_sel == st_q.ilv))
            |=> $stable(word_addr) && $stable(burst_pos));

    // R1: HI_W must leave room for the counter
    initial begin
        a_r1_width_ok: assert (HI_W > 0);
    end
endmodule

// File: tb/burst_addr_seq_bench.sv
`timescale 1ns/1ps
module burst_addr_seq_bench;
    localparam int ADDR_W = 18;
    localparam int CNT_W  = 2;

    typedef struct packed {
        logic              cpu_n;
        logic              cache_n;
        logic              step_n;
        logic              mode;
        logic [ADDR_W-1:0] addr;
        logic [ADDR_W-1:0] exp_addr;
        logic [CNT_W-1:0]  exp_pos;
        logic [1:0]        exp_src;
    } vec_t;

    localparam int NV = 18;
    // cpu cache step mode addr expected_addr pos src
    localparam vec_t VECS [NV] = '{
        '{1'b0,1'b1,1'b1,1'b0,18'h12341,18'h12341,2'd0,2'd1}, // R2 load
        '{1'b1,1'b1,1'b0,1'b0,18'h00000,18'h12342,2'd1,2'd1}, // R5 R7
        '{1'b1,1'b1,1'b0,1'b0,18'h00000,18'h12343,2'd2,2'd1}, // R5
        '{1'b1,1'b1,1'b0,1'b0,18'h00000,18'h12340,2'd3,2'd1}, // R8 wrap no carry
        '{1'b1,1'b1,1'b0,1'b0,18'h00000,18'h12341,2'd0,2'd1}, // R7 pos wraps
        '{1'b1,1'b1,1'b1,1'b0,18'h2AAAA,18'h12341,2'd0,2'd1}, // R9 hold
        '{1'b1,1'b0,1'b1,1'b1,18'h0ABC5,18'h0ABC5,2'd0,2'd2}, // R3 load
        '{1'b1,1'b1,1'b0,1'b1,18'h00000,18'h0ABC4,2'd1,2'd2}, // R6
        '{1'b1,1'b1,1'b0,1'b1,18'h00000,18'h0ABC7,2'd2,2'd2}, // R6
        '{1'b1,1'b1,1'b0,1'b1,18'h00000,18'h0ABC6,2'd3,2'd2}, // R6
        '{1'b1,1'b1,1'b1,1'b1,18'h11111,18'h0ABC6,2'd3,2'd2}, // R9 hold
        '{1'b0,1'b0,1'b0,1'b1,18'h3FFFE,18'h3FFFE,2'd0,2'd1}, // R4 collision
        '{1'b1,1'b1,1'b0,1'b1,18'h00000,18'h3FFFF,2'd1,2'd1}, // R6
        '{1'b1,1'b1,1'b0,1'b1,18'h00000,18'h3FFFC,2'd2,2'd1}, // R6 R8
        '{1'b1,1'b0,1'b0,1'b0,18'h00003,18'h00003,2'd0,2'd2}, // R10 restart
        '{1'b1,1'b1,1'b0,1'b0,18'h00000,18'h00000,2'd1,2'd2}, // R5 R8 no carry
        '{1'b1,1'b1,1'b1,1'b0,18'h11111,18'h00000,2'd1,2'd2}, // R9 addr ignored
        '{1'b1,1'b1,1'b1,1'b1,18'h11111,18'h00002,2'd1,2'd2}  // R6 mode switch
    };

    logic              clk = 1'b0;
    logic              rst_n;
    logic              cpu_strobe_n, cache_strobe_n, step_n, order_sel;
    logic [ADDR_W-1:0] addr_in;
    logic [ADDR_W-1:0] word_addr;
    logic [CNT_W-1:0]  burst_pos;
    logic [1:0]        burst_src;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    burst_addr_seq #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_burst_addr_seq (
        .clk            (clk),
        .rst_n          (rst_n),
        .cpu_strobe_n   (cpu_strobe_n),
        .cache_strobe_n (cache_strobe_n),
        .step_n         (step_n),
        .order_sel      (order_sel),
        .addr_in        (addr_in),
        .word_addr      (word_addr),
        .burst_pos      (burst_pos),
        .burst_src      (burst_src)
    );

    task automatic check(input string req, input logic [ADDR_W-1:0] ea,
                         input logic [CNT_W-1:0] ep, input logic [1:0] es);
        n_chk++;
        if (word_addr !== ea || burst_pos !== ep || burst_src !== es) begin
            n_fail++;
            $display("FAIL %s: addr=%h pos=%0d src=%0d expected addr=%h pos=%0d src=%0d",
                     req, word_addr, burst_pos, burst_src, ea, ep, es);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        #100000;
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        rst_n = 1'b0;
        cpu_strobe_n = 1'b1; cache_strobe_n = 1'b1; step_n = 1'b1;
        order_sel = 1'b0; addr_in = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 reset", '0, '0, 2'd0);
        rst_n = 1'b1;

        // R11: apply at negedge, result visible after the next rising edge
        for (int i = 0; i < NV; i++) begin
            cpu_strobe_n   = VECS[i].cpu_n;
            cache_strobe_n = VECS[i].cache_n;
            step_n         = VECS[i].step_n;
            order_sel      = VECS[i].mode;
            addr_in        = VECS[i].addr;
            @(negedge clk);
            check($sformatf("vector %0d", i), VECS[i].exp_addr,
                  VECS[i].exp_pos, VECS[i].exp_src);
        end

        // R11: strobe pulse between edges is not captured
        cpu_strobe_n = 1'b1; cache_strobe_n = 1'b1; step_n = 1'b1; order_sel = 1'b1;
        @(posedge clk);
        #1 cpu_strobe_n = 1'b0; addr_in = 18'h15555;
        #1 cpu_strobe_n = 1'b1;
        @(negedge clk);
        check("R11 no capture between edges", 18'h00002, 2'd1, 2'd2);

        // R1: reset mid-burst clears state
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 reset mid-burst", '0, '0, 2'd0);
        rst_n = 1'b1;

        // R7: step_n high after load keeps pos at 0
        cpu_strobe_n = 1'b0; addr_in = 18'h20002; order_sel = 1'b0;
        @(negedge clk);
        cpu_strobe_n = 1'b1;
        @(negedge clk);
        check("R7 no advance without step", 18'h20002, 2'd0, 2'd1);

        finish_run();
    end
endmodule